// File: doc/BRIEF.md
# Bridge-Steering Pulse-Width Modulator

This block generates one pulse-width modulated waveform and routes it onto four output pins, so it can drive a single load, a half-bridge or a full H-bridge. The time base is a 10-bit count. Its upper 8 bits come from a timer that counts up to a programmable period limit. Its lower 2 bits come from a sub-count that advances at the prescaled clock rate. A 10-bit duty value is written into a master register. It moves into a working copy only when a period ends, so software can update it at any moment without corrupting the current pulse.

A steering stage chooses one of four pin arrangements. In single mode one pin is modulated. In half-bridge mode two pins carry complementary pulses, with a programmable dead time before either one turns on. In the two full-bridge modes one pin is held on, two are held off and one is modulated, and the forward and reverse modes swap the roles of the pins. Two polarity bits, applied after steering, select active-high or active-low levels for the pin pairs.

Top module: `epwm_bridge`

## Requirements
- R1: Directly after reset, all four pins are low, with single mode, polarity 0, a working duty of 0 and a period limit of 0.
- R2: One PWM period lasts 4·S·(P+1) clock cycles. P is the period limit. S is the prescale step, chosen by `presc_sel`: 00 gives S=1, 01 gives S=4, 10 and 11 give S=16.
- R3: Within each period the modulated signal is active for the first min(D·S, period) clock cycles and inactive for the rest. D is the 10-bit working duty.
- R4: The working duty takes the master value {`duty_wdata`, `ctl_wdata[1:0]`} only at the end of a period. A duty write made in the middle of a period changes nothing until the next period starts.
- R5: A duty of 0 keeps the modulated signal inactive at all times. A duty of at least 4·(P+1) keeps it active at all times.
- R6: In single mode (code 00) pin A carries the modulated signal, and pins B, C and D stay inactive.
- R7: In half-bridge mode (code 10), pin A follows the modulated signal and pin B follows its complement. After each transition both pins stay inactive for exactly G clock cycles, where G is the 7-bit value written through `dly_wdata`.
- R8: In full-bridge forward mode (code 01) pin A is active, pins B and C are inactive, and pin D carries the modulated signal.
- R9: In full-bridge reverse mode (code 11) pin C is active, pins A and D are inactive, and pin B carries the modulated signal.
- R10: Polarity bit 0 (`ctl_wdata[4]`) inverts pins A and C. Polarity bit 1 (`ctl_wdata[5]`) inverts pins B and D. Both are applied after steering.
- R11: The control write maps the low duty bits to `ctl_wdata[1:0]`, the mode code to `ctl_wdata[3:2]` and the polarity to `ctl_wdata[5:4]`. Bits 7:6 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| per_we | input | 1 | Write strobe for the period limit |
| per_wdata | input | 8 | Period limit P |
| duty_we | input | 1 | Write strobe for the upper 8 master duty bits |
| duty_wdata | input | 8 | Upper master duty bits |
| ctl_we | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 8 | Low duty bits, mode code, polarity |
| dly_we | input | 1 | Write strobe for the dead time |
| dly_wdata | input | 7 | Dead time G in clock cycles |
| presc_sel | input | 2 | Prescale step select |
| pin_a | output | 1 | Bridge pin A |
| pin_b | output | 1 | Bridge pin B |
| pin_c | output | 1 | Bridge pin C |
| pin_d | output | 1 | Bridge pin D |

## Verification
The pins are combinational from registered state. A period starts on the clock edge at which the timer wraps, and the new pin levels are valid in the cycle that follows. A register write therefore reaches the pins only at the next period boundary, and a dead time shows up as G cycles with both pins off, starting in the cycle of the transition. The bench locks onto a rising edge of the modulated reference pin. From that edge it queues an expected pin vector for every cycle of one or two whole periods. Between edges it samples on the falling clock, so each vector is compared in exactly the cycle in which the requirements say it is due.

// File: rtl/epwm_bridge.sv
module epwm_bridge #(
  parameter int TW  = 8,
  parameter int DBW = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           per_we,
  input  logic [TW-1:0]  per_wdata,
  input  logic           duty_we,
  input  logic [TW-1:0]  duty_wdata,
  input  logic           ctl_we,
  input  logic [7:0]     ctl_wdata,
  input  logic           dly_we,
  input  logic [DBW-1:0] dly_wdata,
  input  logic [1:0]     presc_sel,
  output logic           pin_a,
  output logic           pin_b,
  output logic           pin_c,
  output logic           pin_d
);

  localparam int TBW = TW + 2;

  typedef enum logic [1:0] {
    M_SINGLE = 2'b00,
    M_FWD    = 2'b01,
    M_HALF   = 2'b10,
    M_REV    = 2'b11
  } mode_e;

  logic [TW-1:0]  per_q, dhi_q, tmr_q;
  logic [1:0]     dlo_q, pol_q, fine_q;
  mode_e          mode_q;
  logic [DBW-1:0] dly_q, gap_cnt;
  logic [3:0]     dcnt, step_m1;
  logic [TBW-1:0] duty_s;
  logic           tick, wrap, pwm, pwm_d, gap;
  logic           act_a, act_b, act_c, act_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= '0;
      dhi_q  <= '0;
      dlo_q  <= '0;
      pol_q  <= '0;
      mode_q <= M_SINGLE;
      dly_q  <= '0;
    end else begin
      if (per_we)  per_q <= per_wdata;
      if (duty_we) dhi_q <= duty_wdata;
      if (dly_we)  dly_q <= dly_wdata;
      if (ctl_we) begin
        dlo_q  <= ctl_wdata[1:0];
        mode_q <= mode_e'(ctl_wdata[3:2]);
        pol_q  <= ctl_wdata[5:4];
      end
    end
  end

  assign step_m1 = (presc_sel == 2'b00) ? 4'd0 : (presc_sel == 2'b01) ? 4'd3 : 4'd15;
  assign tick    = (dcnt >= step_m1);
  assign wrap    = tick && (fine_q == 2'b11) && (tmr_q == per_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt   <= '0;
      fine_q <= '0;
      tmr_q  <= '0;
      duty_s <= '0;
    end else begin
      dcnt <= tick ? 4'd0 : dcnt + 4'd1;
      if (tick) begin
        fine_q <= fine_q + 2'd1;
        if (fine_q == 2'b11) begin
          if (tmr_q == per_q) begin
            tmr_q  <= '0;
            duty_s <= {dhi_q, dlo_q};
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
      end
    end
  end

  assign pwm = ({tmr_q, fine_q} < duty_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_d   <= 1'b0;
      gap_cnt <= '0;
    end else begin
      pwm_d <= pwm;
      if (pwm != pwm_d)
        gap_cnt <= (dly_q == '0) ? '0 : dly_q - 1'b1;
      else if (gap_cnt != '0)
        gap_cnt <= gap_cnt - 1'b1;
    end
  end

  assign gap = ((pwm != pwm_d) && (dly_q != '0)) || (gap_cnt != '0);

  always_comb begin
    {act_a, act_b, act_c, act_d} = 4'b0000;
    unique case (mode_q)
      M_SINGLE: act_a = pwm;
      M_HALF: begin
        act_a = pwm && !gap;
        act_b = !pwm && !gap;
      end
      M_FWD: begin
        act_a = 1'b1;
        act_d = pwm;
      end
      M_REV: begin
        act_c = 1'b1;
        act_b = pwm;
      end
    endcase
  end

  assign pin_a = act_a ^ pol_q[0];
  assign pin_c = act_c ^ pol_q[0];
  assign pin_b = act_b ^ pol_q[1];
  assign pin_d = act_d ^ pol_q[1];

  a_r2_wrap_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (tmr_q == '0 && fine_q == 2'b00));

  a_r4_slave_latch: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (duty_s == $past({dhi_q, dlo_q})));

  a_r4_slave_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(duty_s));

  a_r6_single_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SINGLE) |-> (!(pin_b ^ pol_q[1]) && !(pin_c ^ pol_q[0]) && !(pin_d ^ pol_q[1])));

  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_HALF) |-> !((pin_a ^ pol_q[0]) && (pin_b ^ pol_q[1])));

  a_r8_fwd_levels: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_FWD) |-> ((pin_a ^ pol_q[0]) && !(pin_b ^ pol_q[1]) && !(pin_c ^ pol_q[0])));

  a_r9_rev_levels: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_REV) |-> ((pin_c ^ pol_q[0]) && !(pin_a ^ pol_q[0]) && !(pin_d ^ pol_q[1])));

endmodule

// File: tb/epwm_bridge_tb_top.sv
`timescale 1ns/1ps
module epwm_bridge_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       per_we = 1'b0, duty_we = 1'b0, ctl_we = 1'b0, dly_we = 1'b0;
  logic [7:0] per_wdata = '0, duty_wdata = '0, ctl_wdata = '0;
  logic [6:0] dly_wdata = '0;
  logic [1:0] presc_sel = '0;
  logic       pin_a, pin_b, pin_c, pin_d;

  always #2.5 clk = ~clk;

  epwm_bridge dut_i (
    .clk(clk), .rst_n(rst_n),
    .per_we(per_we), .per_wdata(per_wdata),
    .duty_we(duty_we), .duty_wdata(duty_wdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .dly_we(dly_we), .dly_wdata(dly_wdata),
    .presc_sel(presc_sel),
    .pin_a(pin_a), .pin_b(pin_b), .pin_c(pin_c), .pin_d(pin_d)
  );

  typedef struct {
    int         cyc;
    logic [3:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    checks = 0;
  int    errs = 0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    item_t it;
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      it = q.pop_front();
      checks++;
      if ({pin_d, pin_c, pin_b, pin_a} !== it.exp || it.cyc != cyc) begin
        errs++;
        $display("FAIL %s cycle %0d: pins dcba=%b expected %b (due cycle %0d)",
                 it.tag, cyc, {pin_d, pin_c, pin_b, pin_a}, it.exp, it.cyc);
      end
    end
  end

  function automatic logic [3:0] model(logic [1:0] m, logic [1:0] pol, int k, int h, int g);
    logic a, b, c, d, pw;
    pw = (k < h);
    {a, b, c, d} = 4'b0000;
    case (m)
      2'b00: a = pw;
      2'b10: begin a = pw && (k >= g); b = !pw && (k >= h + g); end
      2'b01: begin a = 1'b1; d = pw; end
      default: begin c = 1'b1; b = pw; end
    endcase
    return {d ^ pol[1], c ^ pol[0], b ^ pol[1], a ^ pol[0]};
  endfunction

  logic [1:0] cur_mode, cur_pol;
  int cur_per, cur_step, cur_dly;

  task automatic configure(int p, int duty, logic [1:0] m, logic [1:0] pol, logic [1:0] ps, int g);
    @(negedge clk);
    per_we = 1'b1; per_wdata = 8'(p);
    duty_we = 1'b1; duty_wdata = 8'(duty >> 2);
    ctl_we = 1'b1; ctl_wdata = {2'b11, pol, m, 2'(duty)};
    dly_we = 1'b1; dly_wdata = 7'(g);
    presc_sel = ps;
    @(negedge clk);
    per_we = 1'b0; duty_we = 1'b0; ctl_we = 1'b0; dly_we = 1'b0;
    cur_mode = m; cur_pol = pol; cur_per = p; cur_dly = g;
    cur_step = (ps == 2'b00) ? 1 : (ps == 2'b01) ? 4 : 16;
  endtask

  task automatic write_duty(int duty);
    @(negedge clk);
    duty_we = 1'b1; duty_wdata = 8'(duty >> 2);
    ctl_we = 1'b1; ctl_wdata = {2'b00, cur_pol, cur_mode, 2'(duty)};
    @(negedge clk);
    duty_we = 1'b0; ctl_we = 1'b0;
  endtask

  function automatic logic ref_act();
    case (cur_mode)
      2'b00, 2'b10: return pin_a ^ cur_pol[0];
      2'b01:        return pin_d ^ cur_pol[1];
      default:      return pin_b ^ cur_pol[1];
    endcase
  endfunction

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  // Locks onto a period start and queues nper periods; the second uses duty d2.
  task automatic expect_periods(string tag, int duty, int d2, int nper, int mid_duty);
    int per_len, h, h2, off, kk;
    logic prev, now;
    item_t it;
    per_len = 4 * cur_step * (cur_per + 1);
    h  = (duty * cur_step > per_len) ? per_len : duty * cur_step;
    h2 = (d2 * cur_step > per_len) ? per_len : d2 * cur_step;
    repeat (per_len + 4) @(negedge clk);
    if (h == 0 || h == per_len) begin
      for (int j = 1; j <= per_len; j++) begin
        it.cyc = cyc + j; it.exp = model(cur_mode, cur_pol, j % per_len, h, cur_dly); it.tag = tag;
        q.push_back(it);
      end
    end else begin
      off  = (cur_mode == 2'b10) ? cur_dly : 0;
      prev = ref_act();
      forever begin
        @(negedge clk);
        now = ref_act();
        if (!prev && now) break;
        prev = now;
      end
      for (int j = 1; j <= nper * per_len; j++) begin
        kk = off + j;
        it.cyc = cyc + j;
        it.exp = model(cur_mode, cur_pol, kk % per_len, (kk / per_len == 0) ? h : h2, cur_dly);
        it.tag = tag;
        q.push_back(it);
      end
      if (mid_duty >= 0) begin
        repeat (4) @(negedge clk);
        write_duty(mid_duty);
      end
    end
    drain();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({pin_d, pin_c, pin_b, pin_a} !== 4'b0000) begin
      errs++;
      $display("FAIL R1 in reset: pins dcba=%b expected 0000", {pin_d, pin_c, pin_b, pin_a});
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    checks++;
    if ({pin_d, pin_c, pin_b, pin_a} !== 4'b0000) begin
      errs++;
      $display("FAIL R1 after reset: pins dcba=%b expected 0000", {pin_d, pin_c, pin_b, pin_a});
    end

    configure(9, 15, 2'b00, 2'b00, 2'b00, 0);
    expect_periods("R3/R6/R11", 15, 15, 1, -1);
    configure(4, 7, 2'b00, 2'b00, 2'b01, 0);
    expect_periods("R2 step4", 7, 7, 1, -1);
    configure(2, 5, 2'b00, 2'b00, 2'b10, 0);
    expect_periods("R2 step16", 5, 5, 1, -1);
    configure(9, 12, 2'b00, 2'b00, 2'b00, 0);
    expect_periods("R4", 12, 30, 2, 30);
    configure(9, 0, 2'b00, 2'b00, 2'b00, 0);
    expect_periods("R5 zero", 0, 0, 1, -1);
    configure(9, 1023, 2'b00, 2'b00, 2'b00, 0);
    expect_periods("R5 full", 1023, 1023, 1, -1);
    configure(9, 20, 2'b10, 2'b00, 2'b00, 3);
    expect_periods("R7 gap3", 20, 20, 1, -1);
    configure(9, 17, 2'b10, 2'b00, 2'b00, 0);
    expect_periods("R7 gap0", 17, 17, 1, -1);
    configure(9, 10, 2'b01, 2'b00, 2'b00, 0);
    expect_periods("R8", 10, 10, 1, -1);
    configure(9, 25, 2'b11, 2'b00, 2'b00, 0);
    expect_periods("R9", 25, 25, 1, -1);
    configure(9, 22, 2'b10, 2'b11, 2'b00, 2);
    expect_periods("R10 half", 22, 22, 1, -1);
    configure(9, 13, 2'b01, 2'b01, 2'b00, 0);
    expect_periods("R10 fwd", 13, 13, 1, -1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: run hung, actual still running expected finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule